// File: doc/BRIEF.md
# Shared Prescaler with Per-Timer Tick Selection

This block holds one free-running prescaler counter, clocked by the system clock, and serves several timer channels (two by default) from it. Each channel has its own 3-bit select code. From the code, the channel builds a single-cycle count-enable strobe, which the timer it feeds uses as a clock enable. No gated clock is ever produced.

A channel can take its strobe from any of these sources:
- nothing (the channel is stopped);
- every system clock cycle;
- one of four taps of the shared divider;
- an edge strobe that arrives already synchronised and polarity-resolved from outside.

A synchronous prescaler-restart input clears the shared divider. The restart therefore moves the tap phase for every channel at once. Because the divider never stops, the time from selecting a tap to its first strobe depends on where the divider happens to be.

Top module: `dual_tick_prescaler`

## Requirements
- R1: Select code 0 (binary 000) holds that channel's countEn low, whatever its extTick does.
- R2: Select code 1 (001) holds countEn high in every cycle, including cycles in which prescRst is high.
- R3: Select codes 2, 3, 4 and 5 choose divide-by-8, 64, 256 and 1024 respectively.
  - The strobe is high for one cycle, in the cycle where the low 3, 6, 8 or 10 bits of the prescaler count are all ones.
  - The strobe therefore repeats every N cycles.
- R4: Select codes 6 (110) and 7 (111) copy that channel's extTick to its countEn in the same cycle, unchanged.
- R5: Neither channel's select code alters the prescaler. Changing one channel's code every cycle leaves the strobe spacing of another channel unchanged.
- R6: All channels share one prescaler. Two channels on the same tap code strobe in exactly the same cycles.
- R7: While prescRst is high, no tap strobe is produced. The count is zero in the following cycle, so the first divide-by-N strobe falls N cycles after the restart cycle.
- R8: rstN (active low, asynchronous) clears the prescaler. With a tap code selected as reset is released, the first divide-by-N strobe occurs in the N-th cycle after release.
- R9: After a channel switches to a tap code, its first strobe arrives within 1 to N cycles, counting the first cycle in which the new code is applied.
- R10: Each channel's select code sits in selCode at bits [3*i+2 : 3*i]. Channel i's extTick is bit i of extTick, and its strobe is bit i of countEn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| prescRst | input | 1 | Synchronous restart of the shared divider |
| selCode | input | 3*NUM_TIMERS | Per-channel select codes, channel i at bits [3*i+2:3*i] |
| extTick | input | NUM_TIMERS | Per-channel external edge strobes, already synchronised |
| countEn | output | NUM_TIMERS | Per-channel single-cycle count-enable strobes |

## Verification
The bench first measures the exact cycle of the first divide-by-1024 strobe after reset release; a counter that came out of reset at a non-zero value, or a tap placed off by one, moves that cycle. It also measures the gap from a prescaler restart to the next divide-by-8 and divide-by-64 strobes. A design that left strobes live during the restart, or cleared only some taps, would fire early or double-pulse there.

While one channel's code changes every cycle, the bench checks that the other channel keeps its cadence. This catches a prescaler wrongly tied to a channel's select code. Finally, the bench compares two channels on the same tap cycle by cycle and bounds the first-strobe latency after a code switch. A separate divider per channel, or a divider reset on selection, breaks one of these checks.

// File: rtl/tick_prescaler_pkg.sv
package tick_prescaler_pkg;

  localparam int SEL_W    = 3;
  localparam int NUM_TAPS = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_STOP     = 3'd0,
    SEL_DIRECT   = 3'd1,
    SEL_DIV8     = 3'd2,
    SEL_DIV64    = 3'd3,
    SEL_DIV256   = 3'd4,
    SEL_DIV1024  = 3'd5,
    SEL_EXT_FALL = 3'd6,
    SEL_EXT_RISE = 3'd7
  } selCode_e;

  // log2 of each tap's divisor, ascending; index = code - 2
  function automatic int tapShift(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

  localparam int PRESC_W = 10;

  // strobes handed from the divider datapath to the select control
  typedef struct packed {
    logic [NUM_TAPS-1:0] tapHit;
  } tapStrobes_t;

endpackage

// File: rtl/presc_divider.sv
module presc_divider
  import tick_prescaler_pkg::*;
#(
  parameter int CNT_W = PRESC_W
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        prescRst,
  output tapStrobes_t strobes
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cnt <= '0;
    else if (prescRst) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  // a tap fires in the cycle its low bits are all ones, i.e. the cycle
  // before they wrap to zero; a restart cancels that wrap
  for (genvar g = 0; g < NUM_TAPS; g++) begin : gTap
    localparam int SH = tapShift(g);
    assign strobes.tapHit[g] = (&cnt[SH-1:0]) && !prescRst;
  end

endmodule

// File: rtl/tick_select.sv
module tick_select
  import tick_prescaler_pkg::*;
(
  input  tapStrobes_t      strobes,
  input  logic [SEL_W-1:0] sel,
  input  logic             extTick,
  output logic             countEn
);

  always_comb begin
    unique case (selCode_e'(sel))
      SEL_STOP:     countEn = 1'b0;
      SEL_DIRECT:   countEn = 1'b1;
      SEL_DIV8:     countEn = strobes.tapHit[0];
      SEL_DIV64:    countEn = strobes.tapHit[1];
      SEL_DIV256:   countEn = strobes.tapHit[2];
      SEL_DIV1024:  countEn = strobes.tapHit[3];
      SEL_EXT_FALL,
      SEL_EXT_RISE: countEn = extTick;
      default:      countEn = 1'b0;
    endcase
  end

endmodule

// File: rtl/dual_tick_prescaler.sv
module dual_tick_prescaler
  import tick_prescaler_pkg::*;
#(
  parameter int NUM_TIMERS = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        prescRst,
  input  logic [NUM_TIMERS*SEL_W-1:0] selCode,
  input  logic [NUM_TIMERS-1:0]       extTick,
  output logic [NUM_TIMERS-1:0]       countEn
);

  tapStrobes_t strobes;

  presc_divider #(.CNT_W(PRESC_W)) uDiv (
    .clk      (clk),
    .rstN     (rstN),
    .prescRst (prescRst),
    .strobes  (strobes)
  );

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : gTimer
    tick_select uSel (
      .strobes (strobes),
      .sel     (selCode[t*SEL_W +: SEL_W]),
      .extTick (extTick[t]),
      .countEn (countEn[t])
    );
  end

endmodule

// File: rtl/tick_prescaler_checker.sv
module tick_prescaler_checker
  import tick_prescaler_pkg::*;
#(
  parameter int NUM_TIMERS = 2
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        prescRst,
  input logic [NUM_TIMERS*SEL_W-1:0] selCode,
  input logic [NUM_TIMERS-1:0]       extTick,
  input logic [NUM_TIMERS-1:0]       countEn
);

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : gChk
    logic [SEL_W-1:0] s;
    logic             isTap;
    assign s     = selCode[t*SEL_W +: SEL_W];
    assign isTap = (s >= 3'd2) && (s <= 3'd5);

    assert_stop_R1: assert property (@(posedge clk) disable iff (!rstN)
      (s == 3'd0) |-> !countEn[t]);

    assert_direct_R2: assert property (@(posedge clk) disable iff (!rstN)
      (s == 3'd1) |-> countEn[t]);

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
      (isTap && countEn[t]) |=> !(isTap && countEn[t]));

    assert_ext_pass_R4: assert property (@(posedge clk) disable iff (!rstN)
      (s >= 3'd6) |-> (countEn[t] == extTick[t]));

    assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
      (prescRst && isTap) |-> !countEn[t]);

    if (t > 0) begin : gShare
      logic [SEL_W-1:0] s0;
      assign s0 = selCode[SEL_W-1:0];
      assert_shared_R6: assert property (@(posedge clk) disable iff (!rstN)
        (isTap && (s == s0)) |-> (countEn[t] == countEn[0]));
    end
  end

endmodule

bind dual_tick_prescaler tick_prescaler_checker #(.NUM_TIMERS(NUM_TIMERS)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .prescRst (prescRst),
  .selCode  (selCode),
  .extTick  (extTick),
  .countEn  (countEn)
);

// File: tb/tb_dual_tick_prescaler.sv
`timescale 1ns/1ps
module tb_dual_tick_prescaler;

  localparam int NT = 2;

  logic          clk = 1'b0;
  logic          rstN;
  logic          prescRst;
  logic [NT*3-1:0] selCode;
  logic [NT-1:0] extTick;
  logic [NT-1:0] countEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int refCnt = 0;

  always #4 clk = ~clk;  // 125 MHz

  dual_tick_prescaler #(.NUM_TIMERS(NT)) dut (
    .clk(clk), .rstN(rstN), .prescRst(prescRst),
    .selCode(selCode), .extTick(extTick), .countEn(countEn)
  );

  // behavioural prescaler model
  always @(posedge clk or negedge rstN) begin
    if (!rstN)         refCnt = 0;
    else if (prescRst) refCnt = 0;
    else               refCnt = (refCnt + 1) % 1024;
  end

  function automatic int divOf(input int code);
    case (code)
      2: return 8;  3: return 64;  4: return 256;  default: return 1024;
    endcase
  endfunction

  function automatic bit expOf(input int code, input int cnt, input bit pr, input bit ext);
    if (code == 0) return 1'b0;
    if (code == 1) return 1'b1;
    if (code >= 6) return ext;
    return ((cnt % divOf(code)) == divOf(code) - 1) && !pr;
  endfunction

  function automatic string tagOf(input int code, input bit pr);
    if (code == 0) return "R1";
    if (code == 1) return "R2";
    if (code >= 6) return "R4";
    if (pr)        return "R7";
    return "R3";
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model (field layout per R10)
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int t = 0; t < NT; t++) begin
        int  code;
        bit  e;
        code = int'(selCode[t*3 +: 3]);
        e    = expOf(code, refCnt, prescRst, extTick[t]);
        check(countEn[t] == e, tagOf(code, prescRst), $sformatf("R10 timer%0d per-cycle countEn", t),
              int'(countEn[t]), int'(e));
      end
    end
  end

  task automatic setSel(input int t, input int code);
    selCode[t*3 +: 3] = 3'(code);
  endtask

  task automatic waitStrobe(input int t, input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!countEn[t] && n < limit);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    int n, k, mism, hits;
    rstN = 1'b0; prescRst = 1'b0; selCode = '0; extTick = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(countEn == '0, "R1", "reset state countEn", int'(countEn), 0);

    // R8: first divide-by-1024 strobe after reset release
    @(posedge clk); #1;
    rstN = 1'b1; setSel(0, 5); setSel(1, 1);
    waitStrobe(0, 2000, n);
    check(n == 1024, "R8", "cycles to first /1024 strobe", n, 1024);

    // R9: first-strobe latency after switching to a tap
    for (int c = 2; c <= 4; c++) begin
      @(posedge clk); #1; setSel(0, 0);
      repeat ($urandom_range(1, 300)) @(posedge clk);
      #1; setSel(0, c);
      waitStrobe(0, 2000, n);
      check(n >= 1 && n <= divOf(c), "R9", $sformatf("first strobe latency code %0d", c), n, divOf(c));
    end

    // R7: restart realigns each tap
    @(posedge clk); #1; setSel(0, 3); setSel(1, 2); prescRst = 1'b1;
    @(posedge clk); #1; prescRst = 1'b0;
    waitStrobe(1, 100, n);
    check(n == 8, "R7", "cycles restart to /8 strobe", n, 8);
    @(posedge clk); #1; prescRst = 1'b1;
    @(posedge clk); #1; prescRst = 1'b0;
    waitStrobe(0, 200, n);
    check(n == 64, "R7", "cycles restart to /64 strobe", n, 64);

    // R2: direct code stays high through restarts
    @(posedge clk); #1; setSel(1, 1);
    k = 0;
    for (int i = 0; i < 40; i++) begin
      prescRst = (i % 5 == 0);
      @(negedge clk); if (!countEn[1]) k++;
      @(posedge clk); #1;
    end
    prescRst = 1'b0;
    check(k == 0, "R2", "low cycles on direct code", k, 0);

    // R5: churn timer1 select, timer0 /8 cadence unchanged
    setSel(0, 2);
    k = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); if (countEn[0]) k++;
      @(posedge clk); #1; setSel(1, $urandom_range(0, 7)); extTick = NT'($urandom);
    end
    check(k == 8, "R5", "/8 strobes in 64 cycles under select churn", k, 8);

    // R6: both channels on the same tap strobe together
    setSel(0, 3); setSel(1, 3);
    mism = 0; hits = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (countEn[0] != countEn[1]) mism++;
      if (countEn[0]) hits++;
    end
    check(mism == 0, "R6", "shared-tap mismatched cycles", mism, 0);
    check(hits >= 4, "R6", "shared-tap strobes seen", hits, 4);

    // R4 and R1: external strobe pass-through and stop code
    @(posedge clk); #1; setSel(0, 6); setSel(1, 7);
    mism = 0;
    for (int i = 0; i < 100; i++) begin
      extTick = NT'($urandom);
      @(negedge clk); if (countEn != extTick) mism++;
      @(posedge clk); #1;
    end
    check(mism == 0, "R4", "ext pass-through mismatches", mism, 0);
    setSel(0, 0); k = 0;
    for (int i = 0; i < 50; i++) begin
      extTick = NT'($urandom);
      @(negedge clk); if (countEn[0]) k++;
      @(posedge clk); #1;
    end
    check(k == 0, "R1", "strobes on stop code", k, 0);

    done = 1;
    summary();
  end

endmodule